// File: doc/BRIEF.md
# Interrupt Request Aggregator with Status Word

This block merges a set of event sources into one active-low interrupt line for a host processor, and keeps a latched status word that tells the host which causes are pending. Sources are the transmit holding register asking for its next byte, the receive FIFO reaching its programmed fill level, power-on, a FIFO overflow or transmit underrun, a wake-up timer expiry, a falling edge on an external interrupt pin, and a supply-low detector. The FIFO-related sources count only while the FIFO is enabled, and the transmit-related sources only while the transmit register is enabled.

Every accepted event sets a sticky flag. The interrupt line stays low while any flag is set. The host reads the status word during a one-cycle read strobe from the serial port. That strobe clears all flags at the next clock edge, except a flag whose event arrives in the same cycle. Level-type inputs (FIFO fill level, supply low) keep setting their flag for as long as they hold. The external pin is asynchronous and passes through a synchroniser before edge detection.

Top module: `irq_collector`

## Requirements
- R1: `irqN` is 0 exactly when at least one flag bit in `statusWord` is 1, and 1 when `statusWord` is all zero.
- R2: After reset the power-on flag (`statusWord[14]`) is 1 and `irqN` is 0. Once that flag is cleared, nothing sets it again until the next reset.
- R3: `fifoLevelEvt` and `fifoOverflowEvt` set their flags only in cycles where `fifoEnable` is 1. Otherwise they have no effect on `statusWord` or `irqN`.
- R4: `txReadyEvt` and `txUnderrunEvt` set their flags only in cycles where `txRegEnable` is 1. Otherwise they have no effect on `statusWord` or `irqN`.
- R5: Status bit map: bit 15 = transmit ready or FIFO level, bit 14 = power-on, bit 13 = overflow or underrun, bit 12 = wake-up, bit 11 = external, bit 10 = supply low. An accepted event appears in its bit after the next rising clock edge.
- R6: A high-to-low transition on `extIrqPinN` sets bit 11, which becomes visible after the third rising edge that follows the transition. A low-to-high transition sets nothing.
- R7: While `statusRead` is 1, `statusWord` still shows the pending flags. After that edge, every flag whose event is not active in the read cycle reads 0.
- R8: An event accepted in the same cycle as `statusRead` leaves its flag set after the read.
- R9: While `lowSupplyEvt` (or an enabled `fifoLevelEvt`) stays high, a read does not clear its flag.
- R10: `statusWord[9:0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; sets the power-on flag |
| fifoEnable | input | 1 | Receive FIFO enabled |
| txRegEnable | input | 1 | Transmit register enabled |
| txReadyEvt | input | 1 | Transmit register ready for next byte (pulse) |
| fifoLevelEvt | input | 1 | FIFO reached programmed bit count (level) |
| fifoOverflowEvt | input | 1 | FIFO overflow (pulse) |
| txUnderrunEvt | input | 1 | Transmit underrun (pulse) |
| wakeTimeoutEvt | input | 1 | Wake-up timer expired (pulse) |
| extIrqPinN | input | 1 | Asynchronous external interrupt pin, idle high |
| lowSupplyEvt | input | 1 | Supply below threshold (level) |
| statusRead | input | 1 | One-cycle status read strobe |
| irqN | output | 1 | Active-low interrupt request |
| statusWord | output | 16 | Latched cause flags, MSB-aligned |

## Verification
Two things can land in the same clock: the host's read-and-clear and a new event setting a flag. The bench raises `statusRead` in the same cycle as a wake-up pulse while a transmit-ready flag is already pending. After the edge it expects the old flag gone and the new one kept. It then holds the supply-low level across a read and expects that flag to survive, and checks that the flag clears once the level drops before the next read.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int NUM_FLAGS = 6;
  // flag indices inside the flag vector; the highest index maps to the status MSB
  localparam int FLAG_LOWSUP = 0;
  localparam int FLAG_EXT    = 1;
  localparam int FLAG_WAKE   = 2;
  localparam int FLAG_OVUN   = 3;
  localparam int FLAG_POR    = 4;
  localparam int FLAG_TXLVL  = 5;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setMask;
    logic                 clearAll;
  } flagCtl_t;
endpackage

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoEnable,
  input  logic     txRegEnable,
  input  logic     txReadyEvt,
  input  logic     fifoLevelEvt,
  input  logic     fifoOverflowEvt,
  input  logic     txUnderrunEvt,
  input  logic     wakeTimeoutEvt,
  input  logic     extIrqPinN,
  input  logic     lowSupplyEvt,
  input  logic     statusRead,
  output flagCtl_t ctl
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic extPrev;
  logic extFall;

  // synchroniser chain for the asynchronous pin, idle level high
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= extIrqPinN;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b1;
    else       extPrev <= syncChain[LAST];
  end

  assign extFall = extPrev & ~syncChain[LAST];

  always_comb begin
    ctl = '0;
    ctl.setMask[FLAG_TXLVL]  = (txRegEnable & txReadyEvt) | (fifoEnable & fifoLevelEvt);
    ctl.setMask[FLAG_POR]    = 1'b0;
    ctl.setMask[FLAG_OVUN]   = (fifoEnable & fifoOverflowEvt) | (txRegEnable & txUnderrunEvt);
    ctl.setMask[FLAG_WAKE]   = wakeTimeoutEvt;
    ctl.setMask[FLAG_EXT]    = extFall;
    ctl.setMask[FLAG_LOWSUP] = lowSupplyEvt;
    ctl.clearAll             = statusRead;
  end
endmodule

// File: rtl/irq_collector_flags.sv
module irq_collector_flags
  import irq_collector_pkg::*;
#(
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagCtl_t            ctl,
  output logic                irqN,
  output logic [STATUS_W-1:0] statusWord
);
  localparam int PAD_W = STATUS_W - NUM_FLAGS;
  localparam logic [NUM_FLAGS-1:0] RESET_FLAGS = NUM_FLAGS'(1) << FLAG_POR;

  logic [NUM_FLAGS-1:0] flagsQ;
  logic [NUM_FLAGS-1:0] flagsD;

  // a new event wins over the read-clear
  always_comb flagsD = ctl.setMask | (flagsQ & ~{NUM_FLAGS{ctl.clearAll}});

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= RESET_FLAGS;
    else       flagsQ <= flagsD;
  end

  assign irqN = ~|flagsQ;

  generate
    if (PAD_W > 0) begin : g_pad
      assign statusWord = {flagsQ, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign statusWord = flagsQ;
    end
  endgenerate
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int STATUS_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fifoEnable,
  input  logic                txRegEnable,
  input  logic                txReadyEvt,
  input  logic                fifoLevelEvt,
  input  logic                fifoOverflowEvt,
  input  logic                txUnderrunEvt,
  input  logic                wakeTimeoutEvt,
  input  logic                extIrqPinN,
  input  logic                lowSupplyEvt,
  input  logic                statusRead,
  output logic                irqN,
  output logic [STATUS_W-1:0] statusWord
);
  flagCtl_t ctl;

  irq_collector_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fifoEnable(fifoEnable), .txRegEnable(txRegEnable),
    .txReadyEvt(txReadyEvt), .fifoLevelEvt(fifoLevelEvt),
    .fifoOverflowEvt(fifoOverflowEvt), .txUnderrunEvt(txUnderrunEvt),
    .wakeTimeoutEvt(wakeTimeoutEvt), .extIrqPinN(extIrqPinN),
    .lowSupplyEvt(lowSupplyEvt), .statusRead(statusRead),
    .ctl(ctl)
  );

  irq_collector_flags #(.STATUS_W(STATUS_W)) u_flags (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .irqN(irqN), .statusWord(statusWord)
  );
endmodule

// File: rtl/irq_collector_checker.sv
module irq_collector_checker #(
  parameter int STATUS_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                fifoEnable,
  input logic                txRegEnable,
  input logic                wakeTimeoutEvt,
  input logic                statusRead,
  input logic                irqN,
  input logic [STATUS_W-1:0] statusWord
);
  localparam int B_TXLVL = STATUS_W - 1;
  localparam int B_POR   = STATUS_W - 2;
  localparam int B_OVUN  = STATUS_W - 3;
  localparam int B_WAKE  = STATUS_W - 4;

  assert_irq_tracks_status_R1: assert property (@(posedge clk) disable iff (!rstN)
    irqN == (statusWord == '0));

  assert_por_never_resets_R2: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[B_POR] |=> !statusWord[B_POR]);

  // covers R4 as well: transmit sources are disabled in the same cycle
  assert_disabled_sources_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !fifoEnable && !txRegEnable) |=> (!statusWord[B_TXLVL] && !statusWord[B_OVUN]));

  assert_read_clears_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !wakeTimeoutEvt) |=> !statusWord[B_WAKE]);

  assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeTimeoutEvt |=> statusWord[B_WAKE]);
endmodule

bind irq_collector irq_collector_checker #(.STATUS_W(STATUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .txRegEnable(txRegEnable),
  .wakeTimeoutEvt(wakeTimeoutEvt), .statusRead(statusRead),
  .irqN(irqN), .statusWord(statusWord)
);

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEnable = 1'b0, txRegEnable = 1'b0;
  logic txReadyEvt = 1'b0, fifoLevelEvt = 1'b0, fifoOverflowEvt = 1'b0, txUnderrunEvt = 1'b0;
  logic wakeTimeoutEvt = 1'b0, extIrqPinN = 1'b1, lowSupplyEvt = 1'b0, statusRead = 1'b0;
  logic irqN;
  logic [15:0] statusWord;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector u_irq_collector (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .txRegEnable(txRegEnable),
    .txReadyEvt(txReadyEvt), .fifoLevelEvt(fifoLevelEvt), .fifoOverflowEvt(fifoOverflowEvt),
    .txUnderrunEvt(txUnderrunEvt), .wakeTimeoutEvt(wakeTimeoutEvt), .extIrqPinN(extIrqPinN),
    .lowSupplyEvt(lowSupplyEvt), .statusRead(statusRead), .irqN(irqN), .statusWord(statusWord)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // compares status and interrupt line; the expected line follows R1
  task automatic expectStatus(string req, logic [15:0] expWord);
    logic expIrq;
    expIrq = (expWord == 16'h0);
    checks++;
    if (statusWord !== expWord || irqN !== expIrq) begin
      fails++;
      $display("FAIL %s: status=%h irqN=%b expected status=%h irqN=%b",
               req, statusWord, irqN, expWord, expIrq);
    end
  endtask

  task automatic readClear();
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    expectStatus("R2 power-on flag after reset", 16'h4000);
    statusRead = 1'b1;
    expectStatus("R7 value visible during read", 16'h4000);
    tick();
    statusRead = 1'b0;
    expectStatus("R7 read clears power-on", 16'h0000);
    repeat (3) tick();
    expectStatus("R2 power-on not set again", 16'h0000);
  endtask

  task automatic testWake();
    wakeTimeoutEvt = 1'b1;
    tick();
    wakeTimeoutEvt = 1'b0;
    expectStatus("R5 wake-up bit 12", 16'h1000);
    readClear();
    expectStatus("R1 line released after clear", 16'h0000);
  endtask

  task automatic testGating();
    fifoEnable = 1'b0; txRegEnable = 1'b0;
    fifoLevelEvt = 1'b1; fifoOverflowEvt = 1'b1; txReadyEvt = 1'b1; txUnderrunEvt = 1'b1;
    tick();
    fifoLevelEvt = 1'b0; fifoOverflowEvt = 1'b0; txReadyEvt = 1'b0; txUnderrunEvt = 1'b0;
    expectStatus("R3 R4 disabled sources ignored", 16'h0000);
    fifoEnable = 1'b1;
    fifoOverflowEvt = 1'b1; txUnderrunEvt = 1'b1; txReadyEvt = 1'b1;
    tick();
    fifoOverflowEvt = 1'b0; txUnderrunEvt = 1'b0; txReadyEvt = 1'b0;
    expectStatus("R3 overflow with FIFO on, R4 tx off", 16'h2000);
    readClear();
    fifoLevelEvt = 1'b1;
    tick();
    fifoLevelEvt = 1'b0;
    expectStatus("R3 FIFO level bit 15", 16'h8000);
    readClear();
    fifoEnable = 1'b0; txRegEnable = 1'b1;
    txReadyEvt = 1'b1;
    tick();
    txReadyEvt = 1'b0;
    expectStatus("R4 tx ready bit 15", 16'h8000);
    readClear();
    txUnderrunEvt = 1'b1;
    tick();
    txUnderrunEvt = 1'b0;
    expectStatus("R4 underrun bit 13", 16'h2000);
    readClear();
    expectStatus("R7 cleared", 16'h0000);
  endtask

  task automatic testExternal();
    extIrqPinN = 1'b0;
    tick();
    expectStatus("R6 not yet after edge 1", 16'h0000);
    tick();
    expectStatus("R6 not yet after edge 2", 16'h0000);
    tick();
    expectStatus("R6 ext bit 11 after edge 3", 16'h0800);
    readClear();
    repeat (3) tick();
    expectStatus("R6 held low pin does not re-set", 16'h0000);
    extIrqPinN = 1'b1;
    repeat (4) tick();
    expectStatus("R6 rising edge ignored", 16'h0000);
  endtask

  task automatic testReadCollision();
    txReadyEvt = 1'b1;
    tick();
    txReadyEvt = 1'b0;
    expectStatus("R5 tx ready pending", 16'h8000);
    statusRead = 1'b1; wakeTimeoutEvt = 1'b1;
    tick();
    statusRead = 1'b0; wakeTimeoutEvt = 1'b0;
    expectStatus("R8 same-cycle event kept, old flag cleared", 16'h1000);
    readClear();
    expectStatus("R7 cleared after collision", 16'h0000);
  endtask

  task automatic testLevels();
    lowSupplyEvt = 1'b1;
    tick();
    expectStatus("R5 supply-low bit 10", 16'h0400);
    readClear();
    expectStatus("R9 held level survives read", 16'h0400);
    lowSupplyEvt = 1'b0;
    readClear();
    expectStatus("R9 clears once level drops", 16'h0000);
    fifoEnable = 1'b1; fifoLevelEvt = 1'b1;
    tick();
    readClear();
    expectStatus("R9 FIFO level survives read", 16'h8000);
    fifoLevelEvt = 1'b0;
    readClear();
    expectStatus("R10 low bits zero, all clear", 16'h0000);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testWake();
    testGating();
    testExternal();
    testReadCollision();
    testLevels();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule